// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers the interrupt conditions of one UART channel and presents them to a host as a single request line and a 6-bit status code. The seven sources are line errors, receive timeout, receive data at or above its trigger, transmit space at or below its trigger, modem-status change, detection of a flow-control stop or special character, and rising edges on the CTS input or RTS output during automatic flow control. Each source has its own set and clear rule. Clears come from read strobes on particular registers, from a write to the transmit holding register, or from the receive FIFO level.

An enable register masks the sources. Its upper bits take effect only while the enhanced-mode input is high. The status code names only the most urgent enabled pending source. Lower sources remain pending and show up once the higher ones are serviced. The FIFOs, the serial engines and the line and modem flag logic are outside the block and reach it only as level and strobe inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register holds 0, `irq` is low, `sleep_en` is low and `isr_code` reads 0x01, the code meaning "nothing pending".
- R2: The enable register bits are: bit0 receive data and receive timeout; bit1 transmit ready; bit2 line status; bit3 modem status; bit4 sleep; bit5 stop/special character; bit6 RTS edge; bit7 CTS edge. Bits 4 to 7 have no effect while `enh_mode` is 0. `sleep_en` equals bit4 AND `enh_mode`. Pending state is kept whatever the enables are, so enabling a source later reveals it.
- R3: `isr_code` reports the highest enabled pending source. The order and codes, from highest to lowest, are: line status 0x06, receive timeout 0x0C, receive data 0x04, transmit ready 0x02, modem status 0x00, stop/special character 0x10, CTS/RTS edge 0x20. Bit 0 is set only in the idle code 0x01.
- R4: A line-status interrupt becomes pending on any clock where one of the four `ls_flags` bits rises. `lsr_rd` clears it. A rise in the same cycle as `lsr_rd` leaves it pending.
- R5: Receive data is a level condition: `rx_level >= rx_trig` and `rx_level` nonzero. It goes away as soon as the level drops below the trigger.
- R6: The receive timeout becomes pending at the clock edge of the (4*`frame_bits`+12)-th `bit_tick` counted while the receive FIFO is nonempty. The count restarts on `rx_push`, on `rhr_rd` or while the FIFO is empty. `rhr_rd` clears the pending timeout.
- R7: Transmit ready becomes pending on a rising edge of `tx_level <= tx_trig`. `thr_wr` clears it, and so does `isr_rd` in a cycle where `isr_code` is 0x02. It does not reassert while the condition stays true.
- R8: A modem-status interrupt becomes pending when any `ms_flags` bit rises. `msr_rd` clears it.
- R9: A `xoff_hit` pulse makes the stop/special interrupt pending. `isr_rd` clears it only in a cycle where `isr_code` is 0x10. A status read while a higher source is reported leaves it pending.
- R10: A rising `cts_in` while `auto_cts` is 1, or a rising `rts_out` while `auto_rts` is 1, makes a flow-edge interrupt pending (code 0x20). Edges while the matching auto mode is 0 are ignored. `msr_rd` clears both the flow-edge and the modem-status interrupts.
- R11: `irq` is the OR of all enabled pending sources and is high exactly when `isr_code` differs from 0x01. It follows changes in pending state and enables with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enh_mode | input | 1 | Enhanced mode; unlocks enable bits 4 to 7 |
| auto_rts | input | 1 | Automatic RTS flow control active |
| auto_cts | input | 1 | Automatic CTS flow control active |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Enable register write data |
| ls_flags | input | 4 | Line error flags (overrun, parity, framing, break) |
| lsr_rd | input | 1 | Line-status register read strobe |
| rx_level | input | 7 | Receive FIFO fill level |
| rx_trig | input | 7 | Receive trigger level |
| rx_push | input | 1 | A character entered the receive FIFO |
| rhr_rd | input | 1 | Receive holding register read strobe |
| bit_tick | input | 1 | One pulse per serial bit time |
| frame_bits | input | 4 | Bits per character frame |
| tx_level | input | 7 | Transmit FIFO fill level |
| tx_trig | input | 7 | Transmit trigger level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_rd | input | 1 | Status register read strobe |
| ms_flags | input | 4 | Modem delta flags |
| msr_rd | input | 1 | Modem-status register read strobe |
| xoff_hit | input | 1 | Stop or special character detected (pulse) |
| cts_in | input | 1 | CTS input level |
| rts_out | input | 1 | RTS output level |
| irq | output | 1 | Interrupt request |
| isr_code | output | 6 | Encoded highest pending source |
| sleep_en | output | 1 | Effective sleep enable |

## Verification
The hardest case to reach from the ports is a queue of several pending sources that drains in the right order. Each service action has to remove exactly one source, or two in the case of a modem-status read, while the others stay queued. The bench walks through all 64 combinations of the six event and level sources. For each combination it raises the chosen sources in one cycle, then services whatever code is reported, in turn, against a pending model it keeps itself. The receive timeout needs long runs of bit ticks. It is swept over a range of frame lengths, and the bench probes one tick before and at the computed limit, then again after a push restarts the count.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 7;

  // source index doubles as priority rank: 0 is the most urgent
  typedef enum logic [2:0] {
    SRC_LS = 3'd0,
    SRC_TO = 3'd1,
    SRC_RX = 3'd2,
    SRC_TX = 3'd3,
    SRC_MS = 3'd4,
    SRC_XO = 3'd5,
    SRC_FL = 3'd6
  } irq_src_e;

  localparam logic [5:0] CODE_NONE = 6'h01;
  localparam logic [5:0] CODE_LS   = 6'h06;
  localparam logic [5:0] CODE_TO   = 6'h0C;
  localparam logic [5:0] CODE_RX   = 6'h04;
  localparam logic [5:0] CODE_TX   = 6'h02;
  localparam logic [5:0] CODE_MS   = 6'h00;
  localparam logic [5:0] CODE_XO   = 6'h10;
  localparam logic [5:0] CODE_FL   = 6'h20;

  // enable register bit positions
  localparam int EN_RXD = 0;
  localparam int EN_TXR = 1;
  localparam int EN_LSR = 2;
  localparam int EN_MSR = 3;
  localparam int EN_SLP = 4;
  localparam int EN_XOF = 5;
  localparam int EN_RTS = 6;
  localparam int EN_CTS = 7;

  function automatic logic [5:0] src_code(input int unsigned idx);
    case (idx)
      0:       return CODE_LS;
      1:       return CODE_TO;
      2:       return CODE_RX;
      3:       return CODE_TX;
      4:       return CODE_MS;
      5:       return CODE_XO;
      6:       return CODE_FL;
      default: return CODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_evt_latch.sv
// Sticky pending bit. EDGE=1: set on any rising bit of src while armed.
// EDGE=0: src is already a pulse. A set beats a clear in the same cycle.
module irq_evt_latch #(
  parameter int W    = 1,
  parameter bit EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         arm,
  input  logic         clr,
  output logic         ev,
  output logic         pend
);

  logic [W-1:0] rise;

  generate
    if (EDGE) begin : g_edge
      logic [W-1:0] src_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
      end
      assign rise = src & ~src_q;
    end else begin : g_pulse
      assign rise = src;
    end
  endgenerate

  assign ev = arm && (|rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (ev)  pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  // shared by R4, R7, R8, R9, R10
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> pend);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> !pend);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !clr) |=> (pend == $past(pend)));

endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int FB_W      = 4,
  parameter int TMO_CHARS = 4,
  parameter int TMO_EXTRA = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_nonempty,
  input  logic            rx_push,
  input  logic            rhr_rd,
  input  logic            bit_tick,
  input  logic [FB_W-1:0] frame_bits,
  output logic            ev_tmo,
  output logic            tmo_pend
);

  localparam int FB_MAX = (1 << FB_W) - 1;
  localparam int CNT_W  = $clog2(TMO_CHARS * FB_MAX + TMO_EXTRA + 1);

  function automatic logic [CNT_W-1:0] tmo_limit(input logic [FB_W-1:0] fb);
    return CNT_W'(TMO_CHARS * int'(fb) + TMO_EXTRA);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             restart;

  assign lim     = tmo_limit(frame_bits);
  assign restart = !rx_nonempty || rx_push || rhr_rd;
  assign ev_tmo  = !restart && bit_tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (bit_tick && cnt < lim) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_pend <= 1'b0;
    else if (ev_tmo) tmo_pend <= 1'b1;
    else if (rhr_rd) tmo_pend <= 1'b0;
  end

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rhr_rd |=> !tmo_pend);
  a_r6_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> (tmo_pend && cnt == $past(lim)));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [5:0]   code,
  output logic [N-1:0] grant
);

  always_comb begin
    code  = CODE_NONE;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        code     = src_code(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (code == CODE_NONE));
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> (code == CODE_LS));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int FB_W       = 4,
  parameter int TMO_CHARS  = 4,
  parameter int TMO_EXTRA  = 12,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_mode,
  input  logic             auto_rts,
  input  logic             auto_cts,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic [3:0]       ls_flags,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rhr_rd,
  input  logic             bit_tick,
  input  logic [FB_W-1:0]  frame_bits,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             thr_wr,
  input  logic             isr_rd,
  input  logic [3:0]       ms_flags,
  input  logic             msr_rd,
  input  logic             xoff_hit,
  input  logic             cts_in,
  input  logic             rts_out,
  output logic             irq,
  output logic [5:0]       isr_code,
  output logic             sleep_en
);

  // enable register
  logic [7:0] ier_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata;
  end

  logic en_xof, en_rts, en_cts;
  assign en_xof   = ier_q[EN_XOF] && enh_mode;
  assign en_rts   = ier_q[EN_RTS] && enh_mode;
  assign en_cts   = ier_q[EN_CTS] && enh_mode;
  assign sleep_en = ier_q[EN_SLP] && enh_mode;

  // named events and pending state
  logic ev_ls, ev_ms, ev_tx, ev_xo, ev_cts, ev_rts, ev_tmo;
  logic p_ls, p_ms, p_tx, p_xo, p_cts, p_rts, p_tmo;
  logic rx_cond, tx_cond;
  logic rd_tx_clr, rd_xo_clr;

  assign rx_cond   = (rx_level >= rx_trig) && (rx_level != '0);
  assign tx_cond   = (tx_level <= tx_trig);
  assign rd_tx_clr = thr_wr || (isr_rd && isr_code == CODE_TX);
  assign rd_xo_clr = isr_rd && (isr_code == CODE_XO);

  irq_evt_latch #(.W(4), .EDGE(1'b1)) u_ls (
    .clk(clk), .rst_n(rst_n), .src(ls_flags), .arm(1'b1),
    .clr(lsr_rd), .ev(ev_ls), .pend(p_ls));

  irq_evt_latch #(.W(4), .EDGE(1'b1)) u_ms (
    .clk(clk), .rst_n(rst_n), .src(ms_flags), .arm(1'b1),
    .clr(msr_rd), .ev(ev_ms), .pend(p_ms));

  irq_evt_latch #(.W(1), .EDGE(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_n), .src(tx_cond), .arm(1'b1),
    .clr(rd_tx_clr), .ev(ev_tx), .pend(p_tx));

  irq_evt_latch #(.W(1), .EDGE(1'b0)) u_xo (
    .clk(clk), .rst_n(rst_n), .src(xoff_hit), .arm(1'b1),
    .clr(rd_xo_clr), .ev(ev_xo), .pend(p_xo));

  irq_evt_latch #(.W(1), .EDGE(1'b1)) u_cts (
    .clk(clk), .rst_n(rst_n), .src(cts_in), .arm(auto_cts),
    .clr(msr_rd), .ev(ev_cts), .pend(p_cts));

  irq_evt_latch #(.W(1), .EDGE(1'b1)) u_rts (
    .clk(clk), .rst_n(rst_n), .src(rts_out), .arm(auto_rts),
    .clr(msr_rd), .ev(ev_rts), .pend(p_rts));

  irq_rx_timeout #(
    .FB_W(FB_W), .TMO_CHARS(TMO_CHARS), .TMO_EXTRA(TMO_EXTRA)
  ) u_tmo (
    .clk(clk), .rst_n(rst_n), .rx_nonempty(rx_level != '0),
    .rx_push(rx_push), .rhr_rd(rhr_rd), .bit_tick(bit_tick),
    .frame_bits(frame_bits), .ev_tmo(ev_tmo), .tmo_pend(p_tmo));

  // masking
  logic [NSRC-1:0] masked;
  logic [NSRC-1:0] grant;
  always_comb begin
    masked         = '0;
    masked[SRC_LS] = p_ls    && ier_q[EN_LSR];
    masked[SRC_TO] = p_tmo   && ier_q[EN_RXD];
    masked[SRC_RX] = rx_cond && ier_q[EN_RXD];
    masked[SRC_TX] = p_tx    && ier_q[EN_TXR];
    masked[SRC_MS] = p_ms    && ier_q[EN_MSR];
    masked[SRC_XO] = p_xo    && en_xof;
    masked[SRC_FL] = (p_cts && en_cts) || (p_rts && en_rts);
  end

  irq_prio_enc #(.N(NSRC)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(masked), .code(isr_code), .grant(grant));

  assign irq = |masked;

  a_r11_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr_code != CODE_NONE));
  a_r2_gated_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> (isr_code != CODE_XO && isr_code != CODE_FL && !sleep_en));
  a_r7_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && isr_code == CODE_TX && !ev_tx) |=> !p_tx);
  a_r10_msr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ev_cts && !ev_rts) |=> (!p_cts && !p_rts));
  a_r10_no_edge_when_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts && !auto_rts) |-> (!ev_cts && !ev_rts));
  a_r9_lower_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (p_xo && isr_rd && isr_code != CODE_XO) |=> p_xo);

endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_mode = 0, auto_rts = 0, auto_cts = 0;
  logic ier_wr = 0;
  logic [7:0] ier_wdata = '0;
  logic [3:0] ls_flags = '0;
  logic lsr_rd = 0;
  logic [6:0] rx_level = '0, rx_trig = 7'd8;
  logic rx_push = 0, rhr_rd = 0, bit_tick = 0;
  logic [3:0] frame_bits = 4'd10;
  logic [6:0] tx_level = 7'd10, tx_trig = 7'd4;
  logic thr_wr = 0, isr_rd = 0;
  logic [3:0] ms_flags = '0;
  logic msr_rd = 0, xoff_hit = 0, cts_in = 0, rts_out = 0;
  logic irq;
  logic [5:0] isr_code;
  logic sleep_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .auto_rts(auto_rts),
    .auto_cts(auto_cts), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ls_flags(ls_flags), .lsr_rd(lsr_rd), .rx_level(rx_level),
    .rx_trig(rx_trig), .rx_push(rx_push), .rhr_rd(rhr_rd),
    .bit_tick(bit_tick), .frame_bits(frame_bits), .tx_level(tx_level),
    .tx_trig(tx_trig), .thr_wr(thr_wr), .isr_rd(isr_rd),
    .ms_flags(ms_flags), .msr_rd(msr_rd), .xoff_hit(xoff_hit),
    .cts_in(cts_in), .rts_out(rts_out), .irq(irq), .isr_code(isr_code),
    .sleep_en(sleep_en));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_code(input string req, input logic [5:0] exp);
    n_tests++;
    if (isr_code !== exp) begin
      n_fail++;
      $display("FAIL %s: isr_code=%h expected %h", req, isr_code, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what,
                         input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s=%b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_ier(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1; tick(); ier_wr = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  // sweep order: 0 line, 1 rx data, 2 tx, 3 modem, 4 stop char, 5 flow edge
  function automatic logic [5:0] sweep_code(input logic [5:0] p);
    logic [5:0] c;
    c = 6'h01;
    if (p[5]) c = 6'h20;
    if (p[4]) c = 6'h10;
    if (p[3]) c = 6'h00;
    if (p[2]) c = 6'h02;
    if (p[1]) c = 6'h04;
    if (p[0]) c = 6'h06;
    return c;
  endfunction

  function automatic int top_of(input logic [5:0] p);
    for (int i = 0; i < 6; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic run_timeout(input int fb);
    int lim;
    lim = 4 * fb + 12;
    frame_bits = 4'(fb);
    rx_level = 7'd1; tick();
    for (int k = 0; k < lim - 1; k++) begin bit_tick = 1; tick(); end
    bit_tick = 0;
    chk_bit("R6", "irq one tick early", irq, 1'b0);
    bit_tick = 1; tick(); bit_tick = 0;
    chk_code("R6", 6'h0C);
    rhr_rd = 1; tick(); rhr_rd = 0;
    chk_code("R6", 6'h01);
    rx_level = 7'd0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11: watchdog cycles=200000 expected fewer");
    summary();
    $finish;
  end

  initial begin
    logic [5:0] p;
    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    chk_code("R1", 6'h01);
    chk_bit("R1", "irq", irq, 1'b0);
    chk_bit("R1", "sleep_en", sleep_en, 1'b0);

    // R2: enables at zero hide a pending line error, enabling reveals it
    ls_flags = 4'b0001; tick(); ls_flags = '0; tick();
    chk_bit("R2", "irq with enables zero", irq, 1'b0);
    write_ier(8'h04);
    chk_code("R2", 6'h06);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk_code("R4", 6'h01);

    // full enable, enhanced mode, automatic flow control
    enh_mode = 1; auto_cts = 1; auto_rts = 1;
    write_ier(8'hFF);
    tx_level = 7'd10; thr_wr = 1; tick(); thr_wr = 0;

    // R3 sweep: every combination of six sources, then drain the queue
    for (int m = 0; m < 64; m++) begin
      ls_flags = '0; ms_flags = '0; cts_in = 0; tx_level = 7'd10; rx_level = '0;
      lsr_rd = 1; msr_rd = 1; thr_wr = 1; tick();
      lsr_rd = 0; msr_rd = 0; thr_wr = 0;
      isr_rd = 1; tick(); isr_rd = 0;
      chk_code("R3", 6'h01);
      p = 6'(m);
      if (p[0]) ls_flags = 4'b0100;
      if (p[1]) rx_level = 7'd8;
      if (p[2]) tx_level = 7'd0;
      if (p[3]) ms_flags = 4'b0010;
      if (p[4]) xoff_hit = 1;
      if (p[5]) cts_in = 1;
      tick();
      xoff_hit = 0;
      for (int step = 0; step < 8; step++) begin
        chk_code("R3", sweep_code(p));
        chk_bit("R11", "irq", irq, p != 0);
        if (p == 0) break;
        case (top_of(p))
          0: begin lsr_rd = 1; tick(); lsr_rd = 0; p[0] = 0; end
          1: begin rx_level = 7'd0; tick(); p[1] = 0; end
          2: begin isr_rd = 1; tick(); isr_rd = 0; p[2] = 0; end
          3: begin msr_rd = 1; tick(); msr_rd = 0; p[3] = 0; p[5] = 0; end
          4: begin isr_rd = 1; tick(); isr_rd = 0; p[4] = 0; end
          default: begin msr_rd = 1; tick(); msr_rd = 0; p[5] = 0; end
        endcase
      end
    end
    ls_flags = '0; ms_flags = '0; cts_in = 0; tx_level = 7'd10; rx_level = '0;
    lsr_rd = 1; msr_rd = 1; thr_wr = 1; tick();
    lsr_rd = 0; msr_rd = 0; thr_wr = 0;
    chk_code("R3", 6'h01);

    // R7 transmit ready: write clears, no refire while condition holds
    tx_level = 7'd4; tick();
    chk_code("R7", 6'h02);
    thr_wr = 1; tick(); thr_wr = 0;
    repeat (3) tick();
    chk_code("R7", 6'h01);
    tx_level = 7'd5; tick(); tx_level = 7'd0; tick();
    chk_code("R7", 6'h02);
    isr_rd = 1; tick(); isr_rd = 0; tick();
    chk_code("R7", 6'h01);
    tx_level = 7'd10; tick();

    // R9 stop char queued under a line error
    xoff_hit = 1; ls_flags = 4'b1000; tick(); xoff_hit = 0;
    chk_code("R9", 6'h06);
    isr_rd = 1; tick(); isr_rd = 0;
    chk_code("R9", 6'h06);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk_code("R9", 6'h10);
    isr_rd = 1; tick(); isr_rd = 0;
    chk_code("R9", 6'h01);

    // R4 rise coinciding with a read keeps the interrupt, a new bit re-raises
    ls_flags = 4'b1010; lsr_rd = 1; tick(); lsr_rd = 0;
    chk_code("R4", 6'h06);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk_code("R4", 6'h01);
    ls_flags = 4'b1011; tick();
    chk_code("R4", 6'h06);
    lsr_rd = 1; ls_flags = '0; tick(); lsr_rd = 0;

    // R8 modem status; code 0x00 still asserts irq
    ms_flags = 4'b1000; tick();
    chk_code("R8", 6'h00);
    chk_bit("R8", "irq", irq, 1'b1);
    msr_rd = 1; ms_flags = '0; tick(); msr_rd = 0;
    chk_code("R8", 6'h01);

    // R10 flow edges
    auto_cts = 0; cts_in = 1; tick();
    chk_code("R10", 6'h01);
    cts_in = 0; auto_cts = 1; rts_out = 1; tick();
    chk_code("R10", 6'h20);
    msr_rd = 1; tick(); msr_rd = 0; rts_out = 0;
    chk_code("R10", 6'h01);

    // R2 enhanced gating of upper enables, sleep output
    enh_mode = 0; xoff_hit = 1; tick(); xoff_hit = 0;
    chk_code("R2", 6'h01);
    chk_bit("R2", "sleep_en", sleep_en, 1'b0);
    enh_mode = 1; #1;
    chk_code("R2", 6'h10);
    chk_bit("R2", "sleep_en", sleep_en, 1'b1);
    isr_rd = 1; tick(); isr_rd = 0;
    chk_code("R9", 6'h01);

    // R11 mask change acts at once; pending survives the mask
    ms_flags = 4'b0001; tick(); ms_flags = '0;
    write_ier(8'h00);
    chk_bit("R11", "irq masked", irq, 1'b0);
    write_ier(8'h08);
    chk_code("R11", 6'h00);
    msr_rd = 1; tick(); msr_rd = 0;
    chk_bit("R11", "irq after last clear", irq, 1'b0);
    write_ier(8'hFF);

    // R5 receive data level
    rx_level = 7'd7; tick();
    chk_code("R5", 6'h01);
    rx_level = 7'd8; #1;
    chk_code("R5", 6'h04);
    rx_level = 7'd9; #1;
    chk_code("R5", 6'h04);
    rx_level = 7'd0; tick();
    chk_code("R5", 6'h01);

    // R6 timeout over a range of frame lengths
    for (int fb = 5; fb <= 12; fb++) run_timeout(fb);

    // R6 push restarts the count
    frame_bits = 4'd10; rx_level = 7'd1; tick();
    for (int k = 0; k < 30; k++) begin bit_tick = 1; tick(); end
    bit_tick = 0; rx_push = 1; tick(); rx_push = 0;
    for (int k = 0; k < 51; k++) begin bit_tick = 1; tick(); end
    bit_tick = 0;
    chk_code("R6", 6'h01);
    bit_tick = 1; tick(); bit_tick = 0;
    chk_code("R6", 6'h0C);
    rhr_rd = 1; tick(); rhr_rd = 0; rx_level = 7'd0; tick();

    // R3 timeout outranks receive data
    frame_bits = 4'd5; rx_level = 7'd8; tick();
    chk_code("R3", 6'h04);
    for (int k = 0; k < 32; k++) begin bit_tick = 1; tick(); end
    bit_tick = 0;
    chk_code("R3", 6'h0C);
    rhr_rd = 1; tick(); rhr_rd = 0;
    chk_code("R3", 6'h04);
    rx_level = 7'd0; tick();
    chk_code("R5", 6'h01);

    summary();
    $finish;
  end

endmodule